// File: doc/BRIEF.md
# Context-Tagged Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking page tables kept in memory. A request carries the virtual address, an access kind (read, write or instruction fetch) and a user/supervisor flag. The walker reads one entry from a context table, selected by a table pointer and the current context number. It then descends through up to three levels of tables. It reads and writes memory through a word port that has a valid/ready handshake and keeps only one read outstanding.

A walk ends at the first leaf entry it finds. A leaf one level down maps 16 MB, two levels down maps 256 KB and three levels down maps 4 KB. A malformed or missing entry ends the walk with an error code that names the level where it stopped. When a leaf is used for the first time, or is first written, the walker sets the referenced and modified bits and stores the word back to the same address before it reports. Permission decoding is left to a separate checker: the walker hands it the leaf's 3-bit access field and echoes the privilege flag.

A bypass setting skips translation entirely. When a boot setting is also on, instruction fetches are steered into a ROM window.

Top module: `ptw_walker`

## Requirements
- R1: After reset `req_ready` is 1, `done` is 0 and `mem_valid` is 0.
- R2: With `cfg_bypass` set and no boot redirection, a request completes without any memory access: `rsp_pa` is the zero-extended virtual address, `rsp_rights` is 3'b111 (bit0 read, bit1 write, bit2 execute), `rsp_size` is 0 and `rsp_err` is 0.
- R3: With `cfg_bypass` and `cfg_boot` set, a fetch (kind 2) returns `cfg_rom_base` ORed with VA[18:0] and `rsp_rights` 3'b101. A read in the same mode still behaves as in R2.
- R4: The first read of a walk is at (`cfg_ctx_ptr` << 4) + (`cfg_ctx_num` << 2).
- R5: Entry bits [1:0] hold the type: 0 invalid, 1 pointer, 2 leaf, 3 reserved. For a pointer, the next read is at ({entry[31:2], 2'b00} << 4) plus 4 times the index. The index is VA[31:24] for the first table level, VA[23:18] for the second and VA[17:12] for the third.
- R6: A leaf at table level 1, 2 or 3 gives `rsp_size` 2 (16 MB), 1 (256 KB) or 0 (4 KB). `rsp_pa` is (entry[31:8] << 12) plus the VA bits below the leaf's index field. `rsp_acc` is entry[4:2].
- R7: An invalid entry at level L (0 for the context entry, up to 3) ends the walk with `rsp_err` = (L << 8) | 4.
- R8: A reserved entry, a leaf in the context table or a pointer at level 3 ends the walk with `rsp_err` = (L << 8) | 16.
- R9: If the leaf's referenced bit (bit 5) is clear, or the access is a write (kind 1) and the modified bit (bit 6) is clear, the walker writes the leaf back to its own address before `done`. The stored word has bit 5 set, and bit 6 set on a write. `rsp_mod` reports the final bit 6.
- R10: If neither condition of R9 holds, no write is issued.
- R11: `mem_valid`, `mem_addr` and `mem_we` hold steady until `mem_ready`. At most one read is outstanding. A request is accepted only while `req_ready` is high, and `req_ready` is low during a walk, so a request raised during a walk is ignored.
- R12: Each accepted request produces exactly one single-cycle `done`. On an error, `rsp_pa` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_va | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch (3 treated as read) |
| req_user | input | 1 | User-mode flag, echoed on the response |
| cfg_bypass | input | 1 | Physical bypass, no table walk |
| cfg_boot | input | 1 | Redirect bypassed fetches to ROM window |
| cfg_rom_base | input | 36 | ROM window base |
| cfg_ctx_ptr | input | 32 | Context table pointer (byte address >> 4) |
| cfg_ctx_num | input | 8 | Current context number |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts the access |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 36 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data returned (at least one cycle after acceptance) |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Result pulse |
| rsp_pa | output | 36 | Physical address |
| rsp_size | output | 2 | 0 4 KB, 1 256 KB, 2 16 MB |
| rsp_err | output | 10 | Error code, 0 on success |
| rsp_acc | output | 3 | Leaf access field |
| rsp_mod | output | 1 | Leaf modified bit after update |
| rsp_rights | output | 3 | Bypass rights {x,w,r}, 0 for walked results |
| rsp_user | output | 1 | Echo of the request's user flag |

## Verification
The bound checker watches the memory port on every cycle. It checks that a request stays steady while stalled, that no second read is issued while one is in flight, that the walker never accepts work while it is using memory, and that every write-back carries the referenced bit. It also checks that an error result always reports a zero physical address. The bench scenarios are the only way to show the translation content: the read addresses at each level, the physical address and size for each leaf depth, the level-tagged error codes, the exact write-back word and the ROM redirection. These depend on the table contents the bench builds.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int unsigned PAGE_W = 12;
    localparam int unsigned IDX1_W = 8;
    localparam int unsigned IDXN_W = 6;
    localparam int unsigned LAST_LVL = 3;

    localparam int unsigned REF_BIT = 5;
    localparam int unsigned MOD_BIT = 6;
    localparam int unsigned ACC_LO = 2;
    localparam int unsigned PPN_LO = 8;

    localparam logic [2:0] FT_INVALID  = 3'd1;
    localparam logic [2:0] FT_RESERVED = 3'd4;

    typedef enum logic [1:0] {
        ET_INV  = 2'd0,
        ET_PTR  = 2'd1,
        ET_LEAF = 2'd2,
        ET_RSV  = 2'd3
    } etype_e;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_FETCH = 2'd2
    } kind_e;

    typedef enum logic [1:0] {
        PG_4K   = 2'd0,
        PG_256K = 2'd1,
        PG_16M  = 2'd2
    } pgsize_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RD    = 2'd1,
        ST_RWAIT = 2'd2,
        ST_WR    = 2'd3
    } state_e;

    // lowest VA bit of the table index used at a given level (1..3)
    function automatic int unsigned idx_lo(input int unsigned lvl);
        return PAGE_W + (LAST_LVL - lvl) * IDXN_W;
    endfunction

    function automatic int unsigned idx_w(input int unsigned lvl);
        return (lvl == 1) ? IDX1_W : IDXN_W;
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int unsigned VA_W   = 32,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned CTX_W  = 8,
    localparam int unsigned PA_W  = WORD_W + 4,
    localparam int unsigned VPN_W = VA_W - ptw_pkg::PAGE_W
) (
    input  logic [1:0]        level,
    input  logic [WORD_W-1:2] ptr_field,
    input  logic [VPN_W-1:0]  vpn,
    input  logic [WORD_W-1:0] ctx_ptr,
    input  logic [CTX_W-1:0]  ctx_num,
    output logic [PA_W-1:0]   addr
);
    import ptw_pkg::*;

    logic [PA_W-1:0] idx_off [0:3];
    logic [PA_W-1:0] tbl_base;
    logic [PA_W-1:0] ctx_addr;

    assign idx_off[0] = '0;

    for (genvar l = 1; l <= 3; l++) begin : g_idx
        localparam int unsigned LO = idx_lo(l) - PAGE_W;
        localparam int unsigned W  = idx_w(l);
        assign idx_off[l] = PA_W'({vpn[LO+W-1:LO], 2'b00});
    end

    assign tbl_base = {ptr_field, 6'b000000};
    assign ctx_addr = {ctx_ptr, 4'b0000} + PA_W'({ctx_num, 2'b00});

    always_comb begin
        if (level == 2'd0) begin
            addr = ctx_addr;
        end else begin
            addr = tbl_base + idx_off[level];
        end
    end

endmodule

// File: rtl/ptw_entry_dec.sv
module ptw_entry_dec #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned ERR_W  = 10
) (
    input  logic [1:0]        level,
    input  logic [WORD_W-1:0] entry,
    input  logic              is_write,
    output logic              go_down,
    output logic              is_leaf,
    output logic              is_fault,
    output logic [ERR_W-1:0]  err,
    output logic              need_wb,
    output logic [WORD_W-1:0] wb_word
);
    import ptw_pkg::*;

    logic [2:0] ft;

    always_comb begin
        go_down = 1'b0;
        is_leaf = 1'b0;
        ft      = FT_INVALID;
        unique case (etype_e'(entry[1:0]))
            ET_INV: ft = FT_INVALID;
            ET_PTR: begin
                if (level != 2'(LAST_LVL)) go_down = 1'b1;
                else                       ft = FT_RESERVED;
            end
            ET_LEAF: begin
                if (level != 2'd0) is_leaf = 1'b1;
                else               ft = FT_RESERVED;
            end
            default: ft = FT_RESERVED;
        endcase
        is_fault = !go_down && !is_leaf;
    end

    assign err = is_fault ? ERR_W'({level, 3'b000, ft, 2'b00}) : '0;

    always_comb begin
        need_wb = !entry[REF_BIT] || (is_write && !entry[MOD_BIT]);
        wb_word = entry;
        wb_word[REF_BIT] = 1'b1;
        if (is_write) wb_word[MOD_BIT] = 1'b1;
    end

endmodule

// File: rtl/ptw_leaf_map.sv
module ptw_leaf_map #(
    parameter int unsigned WORD_W = 32,
    localparam int unsigned PA_W  = WORD_W + 4,
    localparam int unsigned OFF_W = ptw_pkg::idx_lo(1)
) (
    input  logic [1:0]               level,
    input  logic [WORD_W-1:ptw_pkg::PPN_LO] ppn,
    input  logic [OFF_W-1:0]         va_low,
    output logic [PA_W-1:0]          pa,
    output ptw_pkg::pgsize_e         size
);
    import ptw_pkg::*;

    logic [OFF_W-1:0] off [0:3];
    logic [PA_W-1:0]  page_base;

    assign off[0] = '0;

    for (genvar l = 1; l <= 3; l++) begin : g_off
        localparam int unsigned KEEP = idx_lo(l);
        localparam logic [OFF_W-1:0] MASK = OFF_W'((64'd1 << KEEP) - 64'd1);
        assign off[l] = va_low & MASK;
    end

    assign page_base = {ppn, 12'h000};
    assign pa        = page_base + PA_W'(off[level]);

    always_comb begin
        unique case (level)
            2'd1:    size = PG_16M;
            2'd2:    size = PG_256K;
            default: size = PG_4K;
        endcase
    end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
    parameter int unsigned VA_W   = 32,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned CTX_W  = 8,
    parameter int unsigned ROM_W  = 19,
    localparam int unsigned PA_W  = WORD_W + 4,
    localparam int unsigned ERR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic [1:0]        req_kind,
    input  logic              req_user,
    input  logic              cfg_bypass,
    input  logic              cfg_boot,
    input  logic [PA_W-1:0]   cfg_rom_base,
    input  logic [WORD_W-1:0] cfg_ctx_ptr,
    input  logic [CTX_W-1:0]  cfg_ctx_num,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              done,
    output logic [PA_W-1:0]   rsp_pa,
    output logic [1:0]        rsp_size,
    output logic [ERR_W-1:0]  rsp_err,
    output logic [2:0]        rsp_acc,
    output logic              rsp_mod,
    output logic [2:0]        rsp_rights,
    output logic              rsp_user
);
    import ptw_pkg::*;

    localparam int unsigned OFF_W = idx_lo(1);
    localparam logic [2:0] RIGHTS_ALL  = 3'b111;
    localparam logic [2:0] RIGHTS_ROM  = 3'b101;

    typedef struct packed {
        state_e            st;
        logic [1:0]        lvl;
        logic [VA_W-1:0]   va;
        logic              wr;
        logic [PA_W-1:0]   addr;
        logic [WORD_W-1:0] word;
        logic              done;
        logic [PA_W-1:0]   pa;
        pgsize_e           size;
        logic [ERR_W-1:0]  err;
        logic [2:0]        acc;
        logic              mod;
        logic [2:0]        rights;
        logic              user;
    } walk_s;

    walk_s q, d;

    // shared datapath
    logic [1:0]        gen_lvl;
    logic [PA_W-1:0]   nxt_addr;
    logic [VA_W-1:0]   gen_va;
    logic              dec_down, dec_leaf, dec_fault, dec_wb;
    logic [ERR_W-1:0]  dec_err;
    logic [WORD_W-1:0] dec_wb_word;
    logic [PA_W-1:0]   leaf_pa;
    pgsize_e           leaf_size;

    assign gen_lvl = (q.st == ST_IDLE) ? 2'd0 : q.lvl + 2'd1;
    assign gen_va  = (q.st == ST_IDLE) ? req_va : q.va;

    ptw_addr_gen #(
        .VA_W  (VA_W),
        .WORD_W(WORD_W),
        .CTX_W (CTX_W)
    ) i_addr_gen (
        .level    (gen_lvl),
        .ptr_field(mem_rdata[WORD_W-1:2]),
        .vpn      (gen_va[VA_W-1:PAGE_W]),
        .ctx_ptr  (cfg_ctx_ptr),
        .ctx_num  (cfg_ctx_num),
        .addr     (nxt_addr)
    );

    ptw_entry_dec #(
        .WORD_W(WORD_W),
        .ERR_W (ERR_W)
    ) i_entry_dec (
        .level   (q.lvl),
        .entry   (mem_rdata),
        .is_write(q.wr),
        .go_down (dec_down),
        .is_leaf (dec_leaf),
        .is_fault(dec_fault),
        .err     (dec_err),
        .need_wb (dec_wb),
        .wb_word (dec_wb_word)
    );

    ptw_leaf_map #(
        .WORD_W(WORD_W)
    ) i_leaf_map (
        .level (q.lvl),
        .ppn   (mem_rdata[WORD_W-1:PPN_LO]),
        .va_low(q.va[OFF_W-1:0]),
        .pa    (leaf_pa),
        .size  (leaf_size)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.va   = req_va;
                    d.wr   = (req_kind == KIND_WRITE);
                    d.user = req_user;
                    if (cfg_bypass) begin
                        d.done = 1'b1;
                        d.err  = '0;
                        d.size = PG_4K;
                        d.acc  = '0;
                        d.mod  = 1'b0;
                        if (cfg_boot && (req_kind == KIND_FETCH)) begin
                            d.pa     = cfg_rom_base | PA_W'(req_va[ROM_W-1:0]);
                            d.rights = RIGHTS_ROM;
                        end else begin
                            d.pa     = PA_W'(req_va);
                            d.rights = RIGHTS_ALL;
                        end
                    end else begin
                        d.st   = ST_RD;
                        d.lvl  = 2'd0;
                        d.addr = nxt_addr;
                    end
                end
            end
            ST_RD: begin
                if (mem_ready) d.st = ST_RWAIT;
            end
            ST_RWAIT: begin
                if (mem_rvalid) begin
                    if (dec_fault) begin
                        d.st     = ST_IDLE;
                        d.done   = 1'b1;
                        d.err    = dec_err;
                        d.pa     = '0;
                        d.size   = PG_4K;
                        d.acc    = '0;
                        d.mod    = 1'b0;
                        d.rights = '0;
                    end else if (dec_down) begin
                        d.st   = ST_RD;
                        d.lvl  = q.lvl + 2'd1;
                        d.addr = nxt_addr;
                    end else begin
                        d.pa     = leaf_pa;
                        d.size   = leaf_size;
                        d.err    = '0;
                        d.acc    = mem_rdata[ACC_LO+2:ACC_LO];
                        d.rights = '0;
                        d.mod    = dec_wb_word[MOD_BIT];
                        if (dec_wb) begin
                            d.word = dec_wb_word;
                            d.st   = ST_WR;
                        end else begin
                            d.done = 1'b1;
                            d.st   = ST_IDLE;
                        end
                    end
                end
            end
            ST_WR: begin
                if (mem_ready) begin
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready  = (q.st == ST_IDLE);
    assign mem_valid  = (q.st == ST_RD) || (q.st == ST_WR);
    assign mem_we     = (q.st == ST_WR);
    assign mem_addr   = q.addr;
    assign mem_wdata  = q.word;
    assign done       = q.done;
    assign rsp_pa     = q.pa;
    assign rsp_size   = q.size;
    assign rsp_err    = q.err;
    assign rsp_acc    = q.acc;
    assign rsp_mod    = q.mod;
    assign rsp_rights = q.rights;
    assign rsp_user   = q.user;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int unsigned PA_W   = 36,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned ERR_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_we,
    input logic [PA_W-1:0]   mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              mem_rvalid,
    input logic              done,
    input logic [PA_W-1:0]   rsp_pa,
    input logic [ERR_W-1:0]  rsp_err
);
    logic [1:0] rd_out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_out_q <= '0;
        end else begin
            rd_out_q <= rd_out_q
                      + 2'((mem_valid && mem_ready && !mem_we) ? 1 : 0)
                      - 2'(mem_rvalid ? 1 : 0);
        end
    end

    // R11: a stalled access keeps its address and direction
    a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

    // R11: no read issued while another read is in flight
    a_r11_one_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_we) |-> (rd_out_q == 2'd0));

    // R11: no request accepted while memory is in use
    a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !req_ready);

    // R9: every write-back carries the referenced bit
    a_r9_wb_ref_set: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we) |-> mem_wdata[5]);

    // R12: an error result never carries an address
    a_r12_err_no_pa: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (rsp_err != '0)) |-> (rsp_pa == '0));

    // R7 / R8: error codes use only the level and fault-type fields
    a_r8_err_format: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rsp_err[1:0] == 2'b00 && rsp_err[7:5] == 3'b000));

endmodule

bind ptw_walker ptw_walker_chk #(
    .PA_W  (PA_W),
    .WORD_W(WORD_W),
    .ERR_W (ERR_W)
) i_ptw_walker_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rvalid(mem_rvalid),
    .done      (done),
    .rsp_pa    (rsp_pa),
    .rsp_err   (rsp_err)
);

// File: tb/test_ptw_walker.sv
`timescale 1ns/1ps
module test_ptw_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic [1:0]  req_kind = '0;
    logic        req_user = 1'b0;
    logic        cfg_bypass = 1'b0;
    logic        cfg_boot = 1'b0;
    logic [35:0] cfg_rom_base = '0;
    logic [31:0] cfg_ctx_ptr = '0;
    logic [7:0]  cfg_ctx_num = '0;
    logic        mem_valid;
    logic        mem_ready = 1'b1;
    logic        mem_we;
    logic [35:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic [35:0] rsp_pa;
    logic [1:0]  rsp_size;
    logic [9:0]  rsp_err;
    logic [2:0]  rsp_acc;
    logic        rsp_mod;
    logic [2:0]  rsp_rights;
    logic        rsp_user;

    always #10 clk = ~clk;

    ptw_walker i_ptw_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .req_kind(req_kind), .req_user(req_user),
        .cfg_bypass(cfg_bypass), .cfg_boot(cfg_boot), .cfg_rom_base(cfg_rom_base),
        .cfg_ctx_ptr(cfg_ctx_ptr), .cfg_ctx_num(cfg_ctx_num),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done(done), .rsp_pa(rsp_pa), .rsp_size(rsp_size), .rsp_err(rsp_err),
        .rsp_acc(rsp_acc), .rsp_mod(rsp_mod), .rsp_rights(rsp_rights),
        .rsp_user(rsp_user)
    );

    // memory model
    logic [31:0] mem [logic [35:0]];
    logic [35:0] rd_log [0:63];
    int rd_cnt = 0;
    int wr_cnt = 0;
    int done_cnt = 0;
    int cyc_n = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (done) done_cnt = done_cnt + 1;
        if (mem_valid && mem_ready) begin
            if (mem_we) begin
                mem[mem_addr] = mem_wdata;
                wr_cnt = wr_cnt + 1;
            end else begin
                mem_rdata  <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                mem_rvalid <= 1'b1;
                rd_log[rd_cnt % 64] = mem_addr;
                rd_cnt = rd_cnt + 1;
            end
        end
    end

    always @(negedge clk) begin
        cyc_n = cyc_n + 1;
        mem_ready = (cyc_n % 3) != 2;
    end

    // table layout
    localparam logic [31:0] CTXP   = 32'h0010_0000;
    localparam logic [35:0] L1_TBL = 36'h0_0200_0000;
    localparam logic [35:0] L2_TBL = 36'h0_0300_0000;
    localparam logic [35:0] L3_TBL = 36'h0_0400_0000;

    function automatic logic [35:0] ctx_addr(input logic [7:0] c);
        return {CTXP, 4'h0} + {26'h0, c, 2'b00};
    endfunction
    function automatic logic [31:0] mkptr(input logic [35:0] base);
        return {base[35:6], 2'b01};
    endfunction
    function automatic logic [31:0] mkleaf(input logic [23:0] ppn, input logic [2:0] acc,
                                           input logic r, input logic m);
        return {ppn, 1'b0, m, r, acc, 2'b10};
    endfunction
    function automatic logic [35:0] ent_addr(input logic [35:0] tbl, input logic [7:0] idx);
        return tbl + {26'h0, idx, 2'b00};
    endfunction
    function automatic logic [35:0] exp_pa(input logic [31:0] ent, input logic [31:0] va,
                                           input int lvl);
        logic [31:0] off;
        off = (lvl == 1) ? (va & 32'h00FF_FFFF) :
              (lvl == 2) ? (va & 32'h0003_FFFF) : (va & 32'h0000_0FFF);
        return {ent[31:8], 12'h000} + {4'h0, off};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic [31:0] va, input logic [1:0] kind, input logic user);
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_kind = kind; req_user = user;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 300 && !done; i++) @(negedge clk);
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 req_ready after reset", req_ready, 1);
        chk("R1 done after reset", done, 0);
        chk("R1 mem_valid after reset", mem_valid, 0);
    endtask

    task automatic t_bypass();
        int r0;
        cfg_bypass = 1'b1; cfg_boot = 1'b0;
        r0 = rd_cnt;
        do_req(32'h8765_4321, 2'd0, 1'b1);
        chk("R2 done", done, 1);
        chk("R2 pa", rsp_pa, 36'h0_8765_4321);
        chk("R2 rights", rsp_rights, 3'b111);
        chk("R2 err", rsp_err, 0);
        chk("R2 size", rsp_size, 0);
        chk("R2 user echo", rsp_user, 1);
        settle();
        chk("R2 no memory reads", rd_cnt - r0, 0);
        do_req(32'h0000_F00C, 2'd2, 1'b0);
        chk("R2 fetch without boot pa", rsp_pa, 36'h0_0000_F00C);
        settle();
        cfg_bypass = 1'b0;
    endtask

    task automatic t_boot();
        cfg_bypass = 1'b1; cfg_boot = 1'b1; cfg_rom_base = 36'h0_FF00_0000;
        do_req(32'h1237_ABCD, 2'd2, 1'b0);
        chk("R3 rom pa", rsp_pa, 36'h0_FF00_0000 | {17'h0, 19'(32'h1237_ABCD)});
        chk("R3 rom rights", rsp_rights, 3'b101);
        settle();
        do_req(32'h1237_ABCD, 2'd0, 1'b0);
        chk("R3 boot read pa", rsp_pa, 36'h0_1237_ABCD);
        chk("R3 boot read rights", rsp_rights, 3'b111);
        settle();
        cfg_bypass = 1'b0; cfg_boot = 1'b0;
    endtask

    task automatic t_leaf16m();
        int r0, w0;
        logic [31:0] va;
        va = 32'h1234_5678;
        cfg_ctx_num = 8'd5;
        r0 = rd_cnt; w0 = wr_cnt;
        do_req(va, 2'd0, 1'b0);
        chk("R6 16M done", done, 1);
        chk("R6 16M pa", rsp_pa, exp_pa(mem[ent_addr(L1_TBL, va[31:24])], va, 1));
        chk("R6 16M size", rsp_size, 2);
        chk("R6 16M acc", rsp_acc, 3'd3);
        chk("R6 16M err", rsp_err, 0);
        settle();
        chk("R4 context read address", rd_log[r0 % 64], ctx_addr(8'd5));
        chk("R5 level1 read address", rd_log[(r0 + 1) % 64], ent_addr(L1_TBL, va[31:24]));
        chk("R5 read count 16M", rd_cnt - r0, 2);
        chk("R10 no write when R and M set", wr_cnt - w0, 0);
    endtask

    task automatic t_leaf256k();
        int r0, w0;
        logic [31:0] va;
        logic [35:0] la;
        logic [31:0] orig;
        va = 32'h20AB_CDEF;
        la = ent_addr(L2_TBL, {2'b00, va[23:18]});
        orig = mem[la];
        r0 = rd_cnt; w0 = wr_cnt;
        do_req(va, 2'd1, 1'b0);
        chk("R6 256K pa", rsp_pa, exp_pa(orig, va, 2));
        chk("R6 256K size", rsp_size, 1);
        chk("R9 write sets modified", rsp_mod, 1);
        settle();
        chk("R5 level2 read address", rd_log[(r0 + 2) % 64], la);
        chk("R9 one write-back", wr_cnt - w0, 1);
        chk("R9 stored word", mem[la], orig | 32'h60);
    endtask

    task automatic t_leaf4k();
        int r0, w0;
        logic [31:0] va;
        logic [35:0] la;
        logic [31:0] orig;
        va = 32'h30C4_D123;
        la = ent_addr(L3_TBL, {2'b00, va[17:12]});
        orig = mem[la];
        r0 = rd_cnt; w0 = wr_cnt;
        do_req(va, 2'd0, 1'b0);
        chk("R6 4K pa", rsp_pa, exp_pa(orig, va, 3));
        chk("R6 4K size", rsp_size, 0);
        chk("R9 read keeps modified clear", rsp_mod, 0);
        settle();
        chk("R5 level3 read address", rd_log[(r0 + 3) % 64], la);
        chk("R5 read count 4K", rd_cnt - r0, 4);
        chk("R9 read write-back", wr_cnt - w0, 1);
        chk("R9 stored word referenced only", mem[la], orig | 32'h20);
        w0 = wr_cnt;
        do_req(va, 2'd0, 1'b0);
        settle();
        chk("R10 second read no write", wr_cnt - w0, 0);
    endtask

    task automatic t_invalid();
        do_req(32'h2000_0000, 2'd0, 1'b0);
        chk("R7 level2 invalid err", rsp_err, 10'h204);
        chk("R12 error pa zero", rsp_pa, 0);
        @(negedge clk);
        chk("R12 done single cycle", done, 0);
        @(negedge clk);
        cfg_ctx_num = 8'd7;
        do_req(32'h1234_5678, 2'd0, 1'b0);
        chk("R7 context invalid err", rsp_err, 10'h004);
        settle();
        cfg_ctx_num = 8'd5;
    endtask

    task automatic t_reserved();
        cfg_ctx_num = 8'd6;
        do_req(32'h1234_5678, 2'd0, 1'b0);
        chk("R8 leaf in context table", rsp_err, 10'h010);
        settle();
        cfg_ctx_num = 8'd5;
        do_req(32'h4000_0000, 2'd0, 1'b0);
        chk("R8 reserved at level1", rsp_err, 10'h110);
        settle();
        do_req(32'h30C4_E000, 2'd0, 1'b0);
        chk("R8 pointer at level3", rsp_err, 10'h310);
        chk("R8 error pa zero", rsp_pa, 0);
        settle();
    endtask

    task automatic t_busy();
        int r0, d0;
        logic [31:0] va;
        va = 32'h30C4_D456;
        r0 = rd_cnt; d0 = done_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_kind = 2'd0;
        @(negedge clk);
        req_va = 32'h1234_5678; req_kind = 2'd1;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 300 && !done; i++) @(negedge clk);
        chk("R11 first request result kept", rsp_pa,
            exp_pa(mem[ent_addr(L3_TBL, {2'b00, va[17:12]})], va, 3));
        repeat (6) @(negedge clk);
        chk("R11 request during walk ignored", done_cnt - d0, 1);
        chk("R11 reads of one walk", rd_cnt - r0, 4);
    endtask

    initial begin
        mem[ctx_addr(8'd5)] = mkptr(L1_TBL);
        mem[ctx_addr(8'd6)] = mkleaf(24'h00_1000, 3'd1, 1'b1, 1'b1);
        mem[ent_addr(L1_TBL, 8'h12)] = mkleaf(24'h0A_0000, 3'd3, 1'b1, 1'b1);
        mem[ent_addr(L1_TBL, 8'h20)] = mkptr(L2_TBL);
        mem[ent_addr(L1_TBL, 8'h30)] = mkptr(L2_TBL);
        mem[ent_addr(L1_TBL, 8'h40)] = 32'h0000_0003;
        mem[ent_addr(L2_TBL, 8'h2A)] = mkleaf(24'h0B_1200, 3'd1, 1'b1, 1'b0);
        mem[ent_addr(L2_TBL, 8'h31)] = mkptr(L3_TBL);
        mem[ent_addr(L3_TBL, 8'h0D)] = mkleaf(24'h0C_CCCD, 3'd2, 1'b0, 1'b0);
        mem[ent_addr(L3_TBL, 8'h0E)] = mkptr(36'h0_0500_0000);
        cfg_ctx_ptr = CTXP;
        cfg_ctx_num = 8'd5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_boot();
        t_leaf16m();
        t_leaf256k();
        t_leaf4k();
        t_invalid();
        t_reserved();
        t_busy();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL R12 watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule